// File: doc/BRIEF.md
# Block Message Check Generator and Checker

This block guards messages of a block-oriented smart card protocol with an error-detection code. It does this in both directions at once. On the transmit side, bytes flow from a source to the line interface through a valid/ready pass-through. When the message's last byte has been accepted, the block sends the check bytes itself. While it sends them, it holds off the source. On the receive side, the block folds every incoming byte into its own accumulator. It presents the running result as a low byte and a high byte, plus a flag that says whether the residue shows an intact message.

Three inputs set the behaviour. A protocol select turns on the check logic only for the block-oriented protocol. An enable turns generation and checking on or off. A mode input picks either a one-byte XOR longitudinal check or a two-byte CRC-16. A start-of-message marker on each side restarts that side's accumulator.

Top module: `blk_check_unit`

## Requirements
- R1: While no check byte is pending, `tx_out_valid_o`/`tx_out_data_o` equal `tx_in_valid_i`/`tx_in_data_i` in the same cycle, and `tx_in_ready_o` equals `tx_out_ready_i`.
- R2: With `crc_mode_i`=0 the check is the XOR of all message bytes starting from 0x00. Exactly one byte is appended, and `chk_hi_o` reads 0x00.
- R3: With `crc_mode_i`=1 the check is CRC-16 (polynomial 0x1021, initial 0xFFFF, MSB-first, no final XOR). Two bytes are appended, high byte first; the message "123456789" gives 0x29B1.
- R4: While check bytes are pending, `tx_in_ready_o` is 0. A check byte held by `tx_out_ready_i`=0 stays valid and unchanged.
- R5: On receive, `chk_lo_o`/`chk_hi_o` show the check computed over all bytes accepted since the last start-of-message, one cycle after the last byte.
- R6: `rx_good_o` is 1 when the receive residue is zero, which is the case after a message followed by its correct check bytes. It is 0 when a message byte was corrupted.
- R7: A byte flagged with start-of-message restarts the accumulator from the initial value of the selected mode before that byte is folded in.
- R8: With `chk_en_i`=0 no byte is appended on transmit and the receive accumulator does not change.
- R9: With `proto_blk_i`=0, `chk_en_i`=1 has no effect: bytes pass through unchanged, nothing is appended and nothing is accumulated.
- R10: After reset, `chk_lo_o` and `chk_hi_o` are 0x00, `rx_good_o` is 1, and the transmit path is in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| proto_blk_i | input | 1 | 1 = block-oriented protocol, 0 = character-oriented protocol |
| chk_en_i | input | 1 | 1 = generate and check the code |
| crc_mode_i | input | 1 | 1 = CRC-16, 0 = XOR longitudinal check |
| tx_in_valid_i | input | 1 | Source byte valid |
| tx_in_data_i | input | 8 | Source byte |
| tx_in_sop_i | input | 1 | Source byte is the first byte of a message |
| tx_in_last_i | input | 1 | Source byte is the last byte of a message |
| tx_in_ready_o | output | 1 | Block accepts the source byte |
| tx_out_valid_o | output | 1 | Line byte valid |
| tx_out_data_o | output | 8 | Line byte (data or check) |
| tx_out_ready_i | input | 1 | Line interface accepts the byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_sop_i | input | 1 | Received byte is the first byte of a message |
| chk_lo_o | output | 8 | Receive check, low byte |
| chk_hi_o | output | 8 | Receive check, high byte (0x00 in XOR mode) |
| rx_good_o | output | 1 | Receive residue is zero |

## Verification
The hardest situation to reach is a stalled check byte. The line side has to drop ready exactly while the high CRC byte is pending, and the source has to keep offering a new byte at the same time. Only then does the test show that the held byte stays stable and the source byte is not taken. The bench reaches this by lowering line ready right after the last data byte is accepted, and by keeping a decoy source byte valid during the stall. For the receive residue, the bench feeds back the exact byte stream the transmit side produced, so that both directions are checked against one another.

// File: rtl/blk_chk_pkg.sv
package blk_chk_pkg;
  localparam int BYTE_W = 8;
  localparam int CHK_W  = 2 * BYTE_W;
  localparam logic [CHK_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CHK_W-1:0] CRC_INIT = 16'hFFFF;
  localparam logic [CHK_W-1:0] LRC_INIT = '0;

  typedef enum logic [1:0] {PH_DATA, PH_CK_FIRST, PH_CK_LAST} tx_phase_e;

  function automatic logic [CHK_W-1:0] crc_step(logic [CHK_W-1:0] c, logic [BYTE_W-1:0] d);
    logic [CHK_W-1:0] r;
    r = c ^ {d, {(CHK_W-BYTE_W){1'b0}}};
    for (int i = 0; i < BYTE_W; i++)
      r = r[CHK_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/chk_accum.sv
module chk_accum
  import blk_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              sop_i,
  input  logic              crc_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CHK_W-1:0]  acc_o
);
  logic [CHK_W-1:0] base, nxt;

  always_comb begin
    base = sop_i ? (crc_i ? CRC_INIT : LRC_INIT) : acc_o;
    if (crc_i) nxt = crc_step(base, data_i);
    else       nxt = {{(CHK_W-BYTE_W){1'b0}}, base[BYTE_W-1:0] ^ data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (adv_i) acc_o <= nxt;
  end
endmodule

// File: rtl/tx_check_insert.sv
module tx_check_insert
  import blk_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              crc_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i,
  input  logic [CHK_W-1:0]  acc_i,
  output logic              adv_o,
  output logic              chk_phase_o
);
  tx_phase_e phase_q, phase_d;
  logic      two_q, two_d;
  logic      take;

  assign take        = (phase_q == PH_DATA) && in_valid_i && out_ready_i;
  assign adv_o       = take && active_i;
  assign chk_phase_o = (phase_q != PH_DATA);

  always_comb begin
    phase_d     = phase_q;
    two_d       = two_q;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b1;
    out_data_o  = acc_i[BYTE_W-1:0];
    unique case (phase_q)
      PH_DATA: begin
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        if (adv_o && in_last_i) begin
          phase_d = PH_CK_FIRST;
          two_d   = crc_i;
        end
      end
      PH_CK_FIRST: begin
        // CRC sends its high byte first; LRC has only one byte
        out_data_o = two_q ? acc_i[CHK_W-1:BYTE_W] : acc_i[BYTE_W-1:0];
        if (out_ready_i) phase_d = two_q ? PH_CK_LAST : PH_DATA;
      end
      default: begin
        if (out_ready_i) phase_d = PH_DATA;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DATA;
      two_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      two_q   <= two_d;
    end
  end
endmodule

// File: rtl/blk_check_unit.sv
module blk_check_unit
  import blk_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proto_blk_i,
  input  logic              chk_en_i,
  input  logic              crc_mode_i,
  input  logic              tx_in_valid_i,
  input  logic [BYTE_W-1:0] tx_in_data_i,
  input  logic              tx_in_sop_i,
  input  logic              tx_in_last_i,
  output logic              tx_in_ready_o,
  output logic              tx_out_valid_o,
  output logic [BYTE_W-1:0] tx_out_data_o,
  input  logic              tx_out_ready_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_sop_i,
  output logic [BYTE_W-1:0] chk_lo_o,
  output logic [BYTE_W-1:0] chk_hi_o,
  output logic              rx_good_o
);
  logic             active;
  logic [CHK_W-1:0] tx_acc, rx_acc;
  logic             tx_adv;
  logic             chk_phase;

  assign active = proto_blk_i && chk_en_i;

  tx_check_insert u_tx (
    .clk_i, .rst_ni,
    .active_i    (active),
    .crc_i       (crc_mode_i),
    .in_valid_i  (tx_in_valid_i),
    .in_data_i   (tx_in_data_i),
    .in_last_i   (tx_in_last_i),
    .in_ready_o  (tx_in_ready_o),
    .out_valid_o (tx_out_valid_o),
    .out_data_o  (tx_out_data_o),
    .out_ready_i (tx_out_ready_i),
    .acc_i       (tx_acc),
    .adv_o       (tx_adv),
    .chk_phase_o (chk_phase)
  );

  chk_accum u_tx_acc (
    .clk_i, .rst_ni,
    .adv_i  (tx_adv),
    .sop_i  (tx_in_sop_i),
    .crc_i  (crc_mode_i),
    .data_i (tx_in_data_i),
    .acc_o  (tx_acc)
  );

  chk_accum u_rx_acc (
    .clk_i, .rst_ni,
    .adv_i  (rx_valid_i && active),
    .sop_i  (rx_sop_i),
    .crc_i  (crc_mode_i),
    .data_i (rx_data_i),
    .acc_o  (rx_acc)
  );

  assign chk_lo_o  = rx_acc[BYTE_W-1:0];
  assign chk_hi_o  = rx_acc[CHK_W-1:BYTE_W];
  assign rx_good_o = (rx_acc == '0);
endmodule

// File: rtl/blk_check_sva.sv
module blk_check_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       proto_blk_i,
  input logic       chk_en_i,
  input logic       tx_in_valid_i,
  input logic [7:0] tx_in_data_i,
  input logic       tx_in_last_i,
  input logic       tx_in_ready_o,
  input logic       tx_out_valid_o,
  input logic [7:0] tx_out_data_o,
  input logic       tx_out_ready_i,
  input logic       rx_valid_i,
  input logic [7:0] chk_lo_o,
  input logic [7:0] chk_hi_o,
  input logic       chk_phase
);
  p_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_phase |-> (tx_out_valid_o == tx_in_valid_i) && (tx_out_data_o == tx_in_data_i));

  p_enter_chk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_phase && tx_in_valid_i && tx_in_ready_o && tx_in_last_i && proto_blk_i && chk_en_i)
    |=> chk_phase);

  p_no_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_phase |-> !tx_in_ready_o && tx_out_valid_o);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_phase && !tx_out_ready_i) |=> chk_phase && $stable(tx_out_data_o));

  p_rx_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(proto_blk_i && chk_en_i) |=> $stable({chk_hi_o, chk_lo_o}));

  p_no_append_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_phase && !proto_blk_i) |=> !chk_phase);
endmodule

bind blk_check_unit blk_check_sva u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .proto_blk_i    (proto_blk_i),
  .chk_en_i       (chk_en_i),
  .tx_in_valid_i  (tx_in_valid_i),
  .tx_in_data_i   (tx_in_data_i),
  .tx_in_last_i   (tx_in_last_i),
  .tx_in_ready_o  (tx_in_ready_o),
  .tx_out_valid_o (tx_out_valid_o),
  .tx_out_data_o  (tx_out_data_o),
  .tx_out_ready_i (tx_out_ready_i),
  .rx_valid_i     (rx_valid_i),
  .chk_lo_o       (chk_lo_o),
  .chk_hi_o       (chk_hi_o),
  .chk_phase      (chk_phase)
);

// File: tb/blk_check_unit_tb_top.sv
module blk_check_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       proto_blk = 1'b1, chk_en = 1'b1, crc_mode = 1'b1;
  logic       tx_in_valid = 1'b0, tx_in_sop = 1'b0, tx_in_last = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic       tx_in_ready, tx_out_valid;
  logic [7:0] tx_out_data;
  logic       tx_out_ready = 1'b1;
  logic       rx_valid = 1'b0, rx_sop = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] chk_lo, chk_hi;
  logic       rx_good;

  int errors = 0, checks = 0;
  logic [7:0] msg [16];
  logic [7:0] got [4];
  int         ngot;

  always #5 clk = ~clk;

  blk_check_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .proto_blk_i(proto_blk), .chk_en_i(chk_en), .crc_mode_i(crc_mode),
    .tx_in_valid_i(tx_in_valid), .tx_in_data_i(tx_in_data), .tx_in_sop_i(tx_in_sop),
    .tx_in_last_i(tx_in_last), .tx_in_ready_o(tx_in_ready), .tx_out_valid_o(tx_out_valid),
    .tx_out_data_o(tx_out_data), .tx_out_ready_i(tx_out_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_sop_i(rx_sop),
    .chk_lo_o(chk_lo), .chk_hi_o(chk_hi), .rx_good_o(rx_good)
  );

  typedef struct packed {
    logic        mode;
    logic [2:0]  len;
    logic [31:0] bytes;
  } vec_t;
  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 3'd4, 32'hDEADBEEF},
    '{1'b1, 3'd1, 32'h00000000},
    '{1'b0, 3'd3, 32'hA55A0F00},
    '{1'b0, 3'd4, 32'h01020408},
    '{1'b1, 3'd2, 32'hFFFF0000}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // spec model: bit-serial CRC-16, feedback = msb xor data bit
  function automatic logic [15:0] ref_chk(input logic mode, input int n);
    logic [15:0] c;
    if (!mode) begin
      c = 16'h0000;
      for (int i = 0; i < n; i++) c[7:0] = c[7:0] ^ msg[i];
      return c;
    end
    c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ msg[i][b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  // send n bytes, then collect nexp appended bytes; stall line ready for 'stall' cycles on first check byte
  task automatic tx_run(input int n, input int nexp, input int stall, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_in_valid = 1'b1; tx_in_data = msg[i];
      tx_in_sop = (i == 0); tx_in_last = (i == n - 1);
      #1;
      check(tx_out_valid && tx_out_data == msg[i], "R1", tx_out_data, msg[i]);
      check(tx_in_ready == 1'b1, "R1", tx_in_ready, 1);
      @(posedge clk);
    end
    @(negedge clk);
    tx_in_valid = 1'b0; tx_in_sop = 1'b0; tx_in_last = 1'b0;
    ngot = 0;
    for (int k = 0; k < nexp; k++) begin
      #1;
      check(tx_out_valid == 1'b1, req, tx_out_valid, 1);
      check(tx_in_ready == 1'b0, "R4", tx_in_ready, 0);
      if (stall > 0 && k == 0) begin
        logic [7:0] hold;
        hold = tx_out_data;
        tx_out_ready = 1'b0;
        tx_in_valid = 1'b1; tx_in_data = 8'h3C;
        for (int s = 0; s < stall; s++) begin
          @(posedge clk); @(negedge clk); #1;
          check(tx_out_valid && tx_out_data == hold, "R4", tx_out_data, hold);
          check(tx_in_ready == 1'b0, "R4", tx_in_ready, 0);
        end
        tx_in_valid = 1'b0;
        tx_out_ready = 1'b1;
        #1;
      end
      got[ngot] = tx_out_data;
      ngot++;
      @(posedge clk); @(negedge clk);
    end
    #1;
    check(tx_out_valid == 1'b0, req, tx_out_valid, 0);
  endtask

  task automatic rx_run(input int first, input int n, input bit sop_first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = msg[first + i]; rx_sop = sop_first && (i == 0);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] exp;
    int n;
    // R10 reset state
    #1;
    check(chk_lo == 8'h00 && chk_hi == 8'h00, "R10", {chk_hi, chk_lo}, 0);
    check(rx_good == 1'b1, "R10", rx_good, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(tx_in_ready == 1'b1 && tx_out_valid == 1'b0, "R10", {tx_in_ready, tx_out_valid}, 2);

    // vector table: tx append, rx accumulate, rx residue over tx stream
    for (int v = 0; v < NVEC; v++) begin
      crc_mode = VEC[v].mode;
      n = int'(VEC[v].len);
      for (int i = 0; i < n; i++) msg[i] = VEC[v].bytes[31 - 8*i -: 8];
      exp = ref_chk(VEC[v].mode, n);
      tx_run(n, VEC[v].mode ? 2 : 1, 0, VEC[v].mode ? "R3" : "R2");
      if (VEC[v].mode) begin
        check(ngot == 2 && got[0] == exp[15:8] && got[1] == exp[7:0], "R3", {got[0], got[1]}, exp);
      end else begin
        check(ngot == 1 && got[0] == exp[7:0], "R2", got[0], exp[7:0]);
      end
      for (int k = 0; k < ngot; k++) msg[n + k] = got[k];
      rx_run(0, n, 1'b1);
      check(chk_lo == exp[7:0], "R5", chk_lo, exp[7:0]);
      check(chk_hi == (VEC[v].mode ? exp[15:8] : 8'h00), VEC[v].mode ? "R5" : "R2",
            chk_hi, VEC[v].mode ? exp[15:8] : 8'h00);
      rx_run(n, ngot, 1'b0);
      check(rx_good == 1'b1, "R6", rx_good, 1);
    end

    // R3 known vector "123456789" -> 0x29B1, with R4 stall on the high byte
    crc_mode = 1'b1;
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    tx_run(9, 2, 3, "R3");
    check(ngot == 2 && got[0] == 8'h29 && got[1] == 8'hB1, "R3", {got[0], got[1]}, 16'h29B1);

    // R6 corrupted byte with correct check bytes
    msg[9] = 8'h29; msg[10] = 8'hB1; msg[4] = 8'h00;
    rx_run(0, 11, 1'b1);
    check(rx_good == 1'b0, "R6", rx_good, 0);
    msg[4] = 8'h35;

    // R7 start-of-message restart after leftover bytes
    crc_mode = 1'b0;
    msg[0] = 8'h77; msg[1] = 8'h12;
    rx_run(0, 2, 1'b1);
    msg[0] = 8'h0F; msg[1] = 8'hF0; msg[2] = 8'h81;
    rx_run(0, 3, 1'b1);
    check(chk_lo == 8'h7E && chk_hi == 8'h00, "R7", {chk_hi, chk_lo}, 16'h007E);
    crc_mode = 1'b1;
    msg[0] = 8'h31;
    rx_run(0, 1, 1'b1);
    msg[0] = 8'h31; msg[1] = 8'h32; msg[2] = 8'h33;
    exp = ref_chk(1'b1, 3);
    rx_run(0, 3, 1'b1);
    check({chk_hi, chk_lo} == exp, "R7", {chk_hi, chk_lo}, exp);

    // R8 enable off: no append, rx frozen
    chk_en = 1'b0;
    msg[0] = 8'hAA; msg[1] = 8'h55;
    tx_run(2, 0, 0, "R8");
    rx_run(0, 2, 1'b1);
    check({chk_hi, chk_lo} == exp, "R8", {chk_hi, chk_lo}, exp);

    // R9 character protocol: enable has no effect
    chk_en = 1'b1; proto_blk = 1'b0;
    tx_run(2, 0, 0, "R9");
    rx_run(0, 2, 1'b1);
    check({chk_hi, chk_lo} == exp, "R9", {chk_hi, chk_lo}, exp);
    proto_blk = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule